// File: doc/BRIEF.md
# Bridge Presence Announcement Scheduler

This block produces the presence-announcement frames that a two-port network bridge sends so that stations and other bridges learn which network lies behind it. It drives two byte-stream transmitters, one per port. Each transmitter takes a one-cycle start strobe, then bytes under a valid/ready handshake with a last marker, and reports the end of the frame with a done pulse and line activity with a busy level. The block can also cancel the current frame with an abort pulse. The two network numbers and the bridge's own station number are static inputs.

Every announcement is a seven-byte broadcast frame. The bytes are, in order: destination station 0xFF, destination network 0xFF, source station, source network, control 0x80, port 0x9C and one payload byte. The source network is the number of the port the frame leaves on. The payload is the number of the network on the other port. One template serves both ports, and only the two network bytes change with the side. After reset the block announces once on port A and then once on port B. After that it goes idle. In idle, a down-counting timer paces re-announcements on the side that a select flag picks. A repeat counter stops them after a fixed number, and a rearm pulse starts a new series. A stalled transmitter is abandoned after a bounded wait, and the frame is not retried.

Top module: `bridge_announcer`

## Requirements
- R1: A frame has exactly 7 bytes: 0xFF, 0xFF, srcStn, source network (netA on port A, netB on port B), 0x80, 0x9C, payload. txLast is high only with the seventh byte.
- R2: The payload byte is the network number of the opposite port: netB on port A and netA on port B.
- R3: After reset the first frame goes to port A. The second goes to port B, and its start strobe comes 2 cycles after the cycle in which port A's done is seen.
- R4: A start strobe lasts one cycle, and bytes begin in the next cycle. At most one port is started or sending at any time.
- R5: In idle, a frame's start strobe follows the done cycle of the previous frame by RELOAD+1 cycles.
- R6: The idle timer holds its value in every cycle in which either txBusyA or txBusyB is high.
- R7: A rearm pulse sets the select flag from rearmSideB (0 = port A, 1 = port B), restarts the series and reloads the timer. The next frame starts RELOAD+1 cycles after the rearm cycle, on the selected port.
- R8: A series has exactly REPEATS timed announcements, and the boot frames are not counted. After that no frame is sent until the next rearm or reset.
- R9: If txReady stays low, txAbort pulses in the TIMEOUT-th cycle of txValid and sending stops. The frame is not retried, so the next start comes RELOAD+1 cycles after the abort. The aborted frame counts toward the series.
- R10: If txDone does not come, txAbort pulses TIMEOUT cycles after the cycle in which the last byte was accepted.
- R11: A timeout during the boot frame on port A cancels the boot frame on port B. The next frame is a timed one on port A.
- R12: While rstN is low, no start, valid or abort output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| netA | input | 8 | Network number of port A |
| netB | input | 8 | Network number of port B |
| srcStn | input | 8 | Bridge station number used as source station |
| rearm | input | 1 | One-cycle pulse that starts a new announcement series |
| rearmSideB | input | 1 | Port chosen by rearm: 0 = A, 1 = B |
| txReadyA | input | 1 | Port A accepts the current byte |
| txDoneA | input | 1 | Port A finished the frame |
| txBusyA | input | 1 | Port A line is active |
| txStartA | output | 1 | Frame start strobe to port A |
| txDataA | output | 8 | Frame byte to port A |
| txValidA | output | 1 | txDataA is valid |
| txLastA | output | 1 | Current byte is the last of the frame |
| txAbortA | output | 1 | Port A frame abandoned |
| txReadyB | input | 1 | Port B accepts the current byte |
| txDoneB | input | 1 | Port B finished the frame |
| txBusyB | input | 1 | Port B line is active |
| txStartB | output | 1 | Frame start strobe to port B |
| txDataB | output | 8 | Frame byte to port B |
| txValidB | output | 1 | txDataB is valid |
| txLastB | output | 1 | Current byte is the last of the frame |
| txAbortB | output | 1 | Port B frame abandoned |

## Verification
The scheduler is run through several input patterns. In a plain boot with responsive transmitters, every frame byte and every start time is checked. This shows whether the template patch tells the two ports apart and whether the boot order is right. A busy window held on the port that is not sending tells a timer that freezes from one that only reloads. A rearm toward port B shows that the select flag steers both the port and the patched bytes. Separate stalls, one on byte acceptance and one on the done pulse, tell the two timeout paths apart by their exact abort cycle. A stall on the first boot frame shows that the remaining boot frame is dropped rather than retried.

// File: rtl/ann_pkg.sv
`timescale 1ns/1ps
package ann_pkg;
  localparam int unsigned FRAME_LEN = 7;
  localparam int unsigned IDX_W = $clog2(FRAME_LEN);
  localparam logic [7:0] BCAST_BYTE = 8'hFF;
  localparam logic [7:0] CTRL_BYTE  = 8'h80;
  localparam logic [7:0] PORT_BYTE  = 8'h9C;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_SEND, ST_WAITDONE} annState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearIdx;
    logic stepIdx;
    logic sideB;
    logic startPulse;
    logic sendValid;
    logic abortPulse;
  } annCtl_t;
endpackage

// File: rtl/ann_frame_dp.sv
`timescale 1ns/1ps
module ann_frame_dp
  import ann_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  annCtl_t        ctl,
  input  logic [7:0]     netA,
  input  logic [7:0]     netB,
  input  logic [7:0]     srcStn,
  input  logic [1:0]     txReadyV,
  input  logic [1:0]     txDoneV,
  output logic [1:0]     txStartV,
  output logic [1:0]     txValidV,
  output logic [1:0]     txLastV,
  output logic [1:0]     txAbortV,
  output logic [7:0]     txByte,
  output logic           selReady,
  output logic           selDone,
  output logic           lastByte
);
  logic [IDX_W-1:0] byteIdx;
  logic [7:0] ownNet, farNet;
  logic [1:0] selVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteIdx <= '0;
    else if (ctl.clearIdx) byteIdx <= '0;
    else if (ctl.stepIdx) byteIdx <= byteIdx + 1'b1;
  end

  // template patch: only the two network bytes depend on the side
  assign ownNet = ctl.sideB ? netB : netA;
  assign farNet = ctl.sideB ? netA : netB;

  always_comb begin
    case (byteIdx)
      IDX_W'(0), IDX_W'(1): txByte = BCAST_BYTE;
      IDX_W'(2):            txByte = srcStn;
      IDX_W'(3):            txByte = ownNet;
      IDX_W'(4):            txByte = CTRL_BYTE;
      IDX_W'(5):            txByte = PORT_BYTE;
      default:              txByte = farNet;
    endcase
  end

  assign lastByte = (byteIdx == IDX_W'(FRAME_LEN - 1));
  assign selVec   = {ctl.sideB, ~ctl.sideB};
  assign selReady = ctl.sideB ? txReadyV[1] : txReadyV[0];
  assign selDone  = ctl.sideB ? txDoneV[1]  : txDoneV[0];

  for (genvar g = 0; g < 2; g++) begin : g_side
    assign txStartV[g] = ctl.startPulse & selVec[g];
    assign txValidV[g] = ctl.sendValid  & selVec[g];
    assign txLastV[g]  = ctl.sendValid  & selVec[g] & lastByte;
    assign txAbortV[g] = ctl.abortPulse & selVec[g];
  end

  // R4
  one_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txValidV[0] && txValidV[1]) && !(txStartV[0] && txStartV[1]));
endmodule

// File: rtl/ann_ctrl.sv
`timescale 1ns/1ps
module ann_ctrl
  import ann_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned RELOAD  = 16'hFFFF,
  parameter int unsigned REPEATS = 4,
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selReady,
  input  logic    selDone,
  input  logic    lastByte,
  input  logic    busyA,
  input  logic    busyB,
  input  logic    rearm,
  input  logic    rearmSideB,
  output annCtl_t ctl
);
  localparam int unsigned REP_W = $clog2(REPEATS + 1);
  localparam int unsigned TO_W  = $clog2(TIMEOUT + 1);

  annState_t        state;
  logic             sideReg;
  logic [1:0]       bootPend;   // bit0 = port A, bit1 = port B
  logic             annEnable;
  logic             annSideB;
  logic [REP_W-1:0] repCnt;
  logic [TIMER_W-1:0] annTimer;
  logic [TO_W-1:0]  toCnt;

  logic bootGo, bootSide, tick, stalled, timedOut;

  assign bootGo   = (bootPend != 2'b00);
  assign bootSide = ~bootPend[0];
  assign tick     = (state == ST_IDLE) && !bootGo && annEnable && !busyA && !busyB;
  assign stalled  = ((state == ST_SEND) && !selReady) ||
                    ((state == ST_WAITDONE) && !selDone);
  assign timedOut = stalled && (toCnt == TO_W'(TIMEOUT - 1));

  always_comb begin
    ctl.clearIdx   = (state == ST_START);
    ctl.stepIdx    = (state == ST_SEND) && selReady && !lastByte;
    ctl.sideB      = sideReg;
    ctl.startPulse = (state == ST_START);
    ctl.sendValid  = (state == ST_SEND);
    ctl.abortPulse = timedOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sideReg   <= 1'b0;
      bootPend  <= 2'b11;
      annEnable <= 1'b1;
      annSideB  <= 1'b0;
      repCnt    <= REP_W'(REPEATS);
      annTimer  <= TIMER_W'(RELOAD);
      toCnt     <= '0;
    end else begin
      if (stalled) toCnt <= toCnt + 1'b1;
      else         toCnt <= '0;

      case (state)
        ST_IDLE: begin
          if (bootGo) begin
            state   <= ST_START;
            sideReg <= bootSide;
          end else if (tick) begin
            if (annTimer <= TIMER_W'(1)) begin
              state   <= ST_START;
              sideReg <= annSideB;
              repCnt  <= repCnt - 1'b1;
              if (repCnt == REP_W'(1)) annEnable <= 1'b0;
            end else begin
              annTimer <= annTimer - 1'b1;
            end
          end
        end
        ST_START: state <= ST_SEND;
        ST_SEND: begin
          if (timedOut) begin
            state    <= ST_IDLE;
            bootPend <= 2'b00;
            annTimer <= TIMER_W'(RELOAD);
          end else if (selReady && lastByte) begin
            state <= ST_WAITDONE;
          end
        end
        default: begin
          if (timedOut) begin
            state    <= ST_IDLE;
            bootPend <= 2'b00;
            annTimer <= TIMER_W'(RELOAD);
          end else if (selDone) begin
            state             <= ST_IDLE;
            bootPend[sideReg] <= 1'b0;
            annTimer          <= TIMER_W'(RELOAD);
          end
        end
      endcase

      if (rearm) begin
        annEnable <= 1'b1;
        annSideB  <= rearmSideB;
        repCnt    <= REP_W'(REPEATS);
        annTimer  <= TIMER_W'(RELOAD);
      end
    end
  end

  // R4
  start_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startPulse |=> (ctl.sendValid && !ctl.startPulse));
  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abortPulse |=> (!ctl.sendValid && !ctl.startPulse));
  // R8
  rep_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    annEnable |-> (repCnt != '0));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !bootGo && (busyA || busyB) && !rearm) |=> $stable(annTimer));
endmodule

// File: rtl/bridge_announcer.sv
`timescale 1ns/1ps
module bridge_announcer
  import ann_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned RELOAD  = 16'hFFFF,
  parameter int unsigned REPEATS = 4,
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] netA,
  input  logic [7:0] netB,
  input  logic [7:0] srcStn,
  input  logic       rearm,
  input  logic       rearmSideB,
  input  logic       txReadyA,
  input  logic       txDoneA,
  input  logic       txBusyA,
  output logic       txStartA,
  output logic [7:0] txDataA,
  output logic       txValidA,
  output logic       txLastA,
  output logic       txAbortA,
  input  logic       txReadyB,
  input  logic       txDoneB,
  input  logic       txBusyB,
  output logic       txStartB,
  output logic [7:0] txDataB,
  output logic       txValidB,
  output logic       txLastB,
  output logic       txAbortB
);
  annCtl_t    ctl;
  logic       selReady, selDone, lastByte;
  logic [1:0] startV, validV, lastV, abortV;
  logic [7:0] txByte;

  ann_ctrl #(
    .TIMER_W(TIMER_W), .RELOAD(RELOAD), .REPEATS(REPEATS), .TIMEOUT(TIMEOUT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .selReady(selReady), .selDone(selDone),
    .lastByte(lastByte), .busyA(txBusyA), .busyB(txBusyB),
    .rearm(rearm), .rearmSideB(rearmSideB), .ctl(ctl)
  );

  ann_frame_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .netA(netA), .netB(netB), .srcStn(srcStn),
    .txReadyV({txReadyB, txReadyA}), .txDoneV({txDoneB, txDoneA}),
    .txStartV(startV), .txValidV(validV), .txLastV(lastV), .txAbortV(abortV),
    .txByte(txByte), .selReady(selReady), .selDone(selDone), .lastByte(lastByte)
  );

  assign txStartA = startV[0];
  assign txStartB = startV[1];
  assign txValidA = validV[0];
  assign txValidB = validV[1];
  assign txLastA  = lastV[0];
  assign txLastB  = lastV[1];
  assign txAbortA = abortV[0];
  assign txAbortB = abortV[1];
  assign txDataA  = txByte;
  assign txDataB  = txByte;
endmodule

// File: tb/tb_bridge_announcer.sv
`timescale 1ns/1ps
module tb_bridge_announcer;
  localparam int RELOAD  = 20;
  localparam int REPEATS = 3;
  localparam int TIMEOUT = 8;
  localparam int BUSY_H  = 15;
  localparam logic [7:0] NET_A = 8'h11;
  localparam logic [7:0] NET_B = 8'h22;
  localparam logic [7:0] STN   = 8'h5A;

  logic clk = 0;
  logic rstN = 0;
  logic rearm = 0, rearmSideB = 0;
  logic [1:0] rdyV = 2'b11, doneV = 2'b00, busyV = 2'b00;
  logic [1:0] startV, validV, lastV, abortV;
  logic [7:0] dataV [2];

  always #2.5 clk = ~clk;

  bridge_announcer #(.TIMER_W(16), .RELOAD(RELOAD), .REPEATS(REPEATS), .TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rstN(rstN), .netA(NET_A), .netB(NET_B), .srcStn(STN),
    .rearm(rearm), .rearmSideB(rearmSideB),
    .txReadyA(rdyV[0]), .txDoneA(doneV[0]), .txBusyA(busyV[0]),
    .txStartA(startV[0]), .txDataA(dataV[0]), .txValidA(validV[0]),
    .txLastA(lastV[0]), .txAbortA(abortV[0]),
    .txReadyB(rdyV[1]), .txDoneB(doneV[1]), .txBusyB(busyV[1]),
    .txStartB(startV[1]), .txDataB(dataV[1]), .txValidB(validV[1]),
    .txLastB(lastV[1]), .txAbortB(abortV[1])
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-frame log, indexed by order of start strobes
  int fSide[64], fStart[64], fDone[64], fAbort[64], fLast[64], fValid[64], fLen[64];
  logic [7:0] fB[64][7];
  int nStart = 0;
  int curIdx[2], byteN[2], doneWait[2];
  bit curStall[2], curNoDone[2];
  int stallSend = 0, stallDone = 0, busyIdx = -1, busyLeft = 0;
  int lastErr = 0, startErr = 0;

  // transmitter models and monitor
  initial begin
    for (int i = 0; i < 64; i++) begin
      fSide[i] = -1; fStart[i] = -1; fDone[i] = -1; fAbort[i] = -1;
      fLast[i] = -1; fValid[i] = 0; fLen[i] = 0;
    end
    for (int s = 0; s < 2; s++) begin
      curIdx[s] = -1; byteN[s] = 0; doneWait[s] = -1; curStall[s] = 0; curNoDone[s] = 0;
    end
    forever begin
      @(negedge clk);
      if (busyLeft > 0) begin busyV[1] = 1'b1; busyLeft--; end
      else busyV[1] = 1'b0;
      for (int s = 0; s < 2; s++) begin
        doneV[s] = 1'b0;
        if (doneWait[s] > 0) begin
          doneWait[s]--;
          if (doneWait[s] == 0) begin
            doneV[s] = 1'b1;
            doneWait[s] = -1;
            fDone[curIdx[s]] = cyc;
            if (curIdx[s] == busyIdx) busyLeft = BUSY_H;
          end
        end
        if (startV[s]) begin
          if (validV[s]) startErr++;
          curIdx[s] = nStart;
          fSide[nStart] = s;
          fStart[nStart] = cyc;
          nStart++;
          byteN[s] = 0;
          curStall[s] = (stallSend > 0);
          if (curStall[s]) stallSend--;
          curNoDone[s] = (stallDone > 0);
          if (curNoDone[s]) stallDone--;
        end
        rdyV[s] = !curStall[s];
        if (validV[s]) begin
          if (curIdx[s] < 0) startErr++;
          else begin
            fValid[curIdx[s]]++;
            if (rdyV[s]) begin
              if (byteN[s] < 7) fB[curIdx[s]][byteN[s]] = dataV[s];
              if (lastV[s] != (byteN[s] == 6)) lastErr++;
              byteN[s]++;
              fLen[curIdx[s]] = byteN[s];
              if (lastV[s]) begin
                fLast[curIdx[s]] = cyc;
                if (!curNoDone[s]) doneWait[s] = 2;
              end
            end
          end
        end
        if (abortV[s] && curIdx[s] >= 0) fAbort[curIdx[s]] = cyc;
      end
    end
  end

  task automatic checkFrame(input int idx, input int side, input string req);
    logic [7:0] exp [7];
    exp[0] = 8'hFF; exp[1] = 8'hFF; exp[2] = STN;
    exp[3] = side ? NET_B : NET_A;
    exp[4] = 8'h80; exp[5] = 8'h9C;
    exp[6] = side ? NET_A : NET_B;
    chk(fLen[idx] == 7, req, fLen[idx], 7);
    for (int j = 0; j < 6; j++) chk(fB[idx][j] === exp[j], req, fB[idx][j], exp[j]);
    chk(fB[idx][6] === exp[6], "R2 payload", fB[idx][6], exp[6]);
  endtask

  task automatic doRearm(input bit sideB, output int rc);
    @(negedge clk);
    rearmSideB = sideB;
    rearm = 1'b1;
    rc = cyc;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  initial begin
    int rc;
    // R12: quiet outputs while in reset
    repeat (3) @(negedge clk);
    chk(startV == 2'b00, "R12 start in reset", startV, 0);
    chk(validV == 2'b00, "R12 valid in reset", validV, 0);
    chk(abortV == 2'b00, "R12 abort in reset", abortV, 0);
    busyIdx = 2;
    rstN = 1'b1;
    repeat (300) @(negedge clk);

    // boot and first series
    chk(fSide[0] == 0, "R3 first boot side", fSide[0], 0);
    chk(fSide[1] == 1, "R3 second boot side", fSide[1], 1);
    chk(fStart[1] == fDone[0] + 2, "R3 boot B start", fStart[1], fDone[0] + 2);
    checkFrame(0, 0, "R1 port A frame");
    checkFrame(1, 1, "R1 port B frame");
    chk(fStart[2] == fDone[1] + RELOAD + 1, "R5 period", fStart[2], fDone[1] + RELOAD + 1);
    chk(fStart[4] == fDone[3] + RELOAD + 1, "R5 period", fStart[4], fDone[3] + RELOAD + 1);
    chk(fStart[3] == fDone[2] + BUSY_H + RELOAD + 1, "R6 busy hold", fStart[3],
        fDone[2] + BUSY_H + RELOAD + 1);
    for (int i = 2; i < 5; i++) chk(fSide[i] == 0, "R7 default side A", fSide[i], 0);
    chk(nStart == 5, "R8 series length", nStart, 5);
    chk(lastErr == 0, "R1 last marker", lastErr, 0);
    chk(startErr == 0, "R4 start then bytes", startErr, 0);

    // rearm toward port B
    doRearm(1'b1, rc);
    repeat (300) @(negedge clk);
    chk(fStart[5] == rc + RELOAD + 1, "R7 rearm timing", fStart[5], rc + RELOAD + 1);
    for (int i = 5; i < 8; i++) chk(fSide[i] == 1, "R7 side B", fSide[i], 1);
    checkFrame(5, 1, "R1 timed port B frame");
    chk(nStart == 8, "R8 second series", nStart, 8);

    // stall on byte acceptance
    stallSend = 1;
    doRearm(1'b0, rc);
    repeat (300) @(negedge clk);
    chk(fAbort[8] == fStart[8] + TIMEOUT, "R9 abort cycle", fAbort[8], fStart[8] + TIMEOUT);
    chk(fValid[8] == TIMEOUT, "R9 valid cycles", fValid[8], TIMEOUT);
    chk(fDone[8] == -1, "R9 no done", fDone[8], -1);
    chk(fStart[9] == fAbort[8] + RELOAD + 1, "R9 no retry", fStart[9], fAbort[8] + RELOAD + 1);
    chk(nStart == 11, "R9 abort counted", nStart, 11);

    // stall on done
    stallDone = 1;
    doRearm(1'b0, rc);
    repeat (300) @(negedge clk);
    chk(fLen[11] == 7, "R10 bytes sent", fLen[11], 7);
    chk(fAbort[11] == fLast[11] + TIMEOUT, "R10 abort cycle", fAbort[11], fLast[11] + TIMEOUT);
    chk(nStart == 14, "R10 series", nStart, 14);

    // stall during boot
    stallSend = 1;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(startV == 2'b00 && validV == 2'b00, "R12 quiet in second reset", {startV, validV}, 0);
    rstN = 1'b1;
    repeat (300) @(negedge clk);
    chk(fSide[14] == 0 && fAbort[14] >= 0, "R11 boot A aborted", fAbort[14], fStart[14] + TIMEOUT);
    chk(fSide[15] == 0, "R11 boot B skipped", fSide[15], 0);
    chk(fStart[15] == fAbort[14] + RELOAD + 1, "R11 timed next", fStart[15], fAbort[14] + RELOAD + 1);
    chk(nStart == 18, "R11 series after boot abort", nStart, 18);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule